// File: doc/BRIEF.md
# Watchdog-Capable Interval Timer

This block is a 16-bit counter driven by a slow 32.768 kHz time base, which arrives as a one-cycle enable pulse (`tick_i`) in the system clock domain. A prescaler passes every tick, every 16th tick or every 256th tick on to the counter. The counter counts up or down. It can wrap freely, or restart on its own at a terminal value. It can also serve as a watchdog. Software has to write to a refresh address before the count runs out. If it does not, the block issues either a one-cycle reset request or a sticky interrupt.

Software sets the timer up through a small register bus. A load-value register can be written at any time. A control word can be written only once after reset, so a runaway program cannot disable a watchdog that is running. A refresh (clear) address reacts to any write. Reading the count address returns the live counter value. A peripheral power-down input can hold the timer still, if the control word allows it.

Top module: `wdt_timer`

## Requirements
- R1: After reset the control word reads 0, the count is 0, and `irq_o` and `rst_req_o` are low. The timer is therefore disabled, counts down, runs free, has the watchdog off and divides by 1.
- R2: Control bits [3:2] choose the prescale. Code 0 steps the counter on every running tick. Code 1 steps it on every 16th tick, code 2 on every 256th tick, and the reserved code 3 acts like code 0. A control write that sets the enable bit restarts the prescaler from zero.
- R3: The control register (address 0) takes only the first write after reset. Every later write to address 0 leaves the read-back value and the timer behaviour unchanged.
- R4: In free-running mode (bit 6 = 0) the counter steps by one and wraps modulo 2^16. Bit 8 sets the direction: 1 counts up, 0 counts down.
- R5: In periodic mode (bit 6 = 1), counting down, a step taken at 0 reloads the load value. Counting up, a step taken at the load value returns the count to 0.
- R6: A control write with the enable bit (bit 7) set copies the load register (address 1) into the counter on the next edge. While the enable bit is 0 the count holds.
- R7: With watchdog mode on (bit 5 = 1) the counter always counts down, whatever bits 8 and 6 say. A step taken at count 1 or 0 is an expiry, and the counter reloads the load value.
- R8: In watchdog mode, with the timer enabled, a write of any value to the clear address (address 2) reloads the counter on the next edge and clears `irq_o`. The same write has no effect when watchdog mode is off.
- R9: When the watchdog expires, bit 1 = 0 makes `rst_req_o` high for exactly the following cycle. Bit 1 = 1 sets `irq_o` instead, and it stays set until a clear write.
- R10: With bit 0 set, the counter and the prescaler freeze while `pd_i` is high. With bit 0 clear, `pd_i` has no effect.
- R11: Reads are combinational on the address. The control read returns 0 in bits 15:9 and bit 4. The load address returns the load value, the clear address reads 0, and address 3 returns the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per period of the 32.768 kHz time base |
| pd_i | input | 1 | Peripheral power-down indication |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address: 0 control, 1 load, 2 clear, 3 count |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i` |
| count_o | output | 16 | Current counter value |
| irq_o | output | 1 | Sticky watchdog interrupt |
| rst_req_o | output | 1 | One-cycle watchdog reset request |

## Verification
Every write and every tick that completes a prescale period changes state on the same rising edge. The new count, `irq_o` and `rst_req_o` are therefore visible from that edge until the next one. `bus_rdata_o` follows the address with no delay, using the state left by the last edge. The bench drives inputs on the falling edge, and its reference model advances on the rising edge from those same inputs. At each following falling edge it compares the count, both request outputs and the read data against the model, so every result is checked in the first cycle in which it is due.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int BUS_W = 16;

    // Control word layout, MSB first (bits 15..0)
    typedef struct packed {
        logic [6:0] rsv_hi;    // 15:9 read as zero
        logic       up;        // 8
        logic       en;        // 7
        logic       periodic;  // 6
        logic       wd;        // 5
        logic       rsv_mid;   // 4 read as zero
        logic [1:0] psc;       // 3:2
        logic       irq_en;    // 1
        logic       pd_off;    // 0
    } wdt_ctrl_t;

    localparam logic [BUS_W-1:0] CTRL_WMASK = 16'h01EF;

    typedef enum logic [1:0] {
        A_CTRL  = 2'd0,
        A_LOAD  = 2'd1,
        A_CLEAR = 2'd2,
        A_COUNT = 2'd3
    } wdt_addr_e;

    typedef enum logic [1:0] {
        PSC_DIV1   = 2'd0,
        PSC_DIV16  = 2'd1,
        PSC_DIV256 = 2'd2,
        PSC_RSVD   = 2'd3
    } wdt_psc_e;

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr_i,
    input  logic [1:0]       bus_addr_i,
    input  logic [BUS_W-1:0] bus_wdata_i,
    input  logic [CNT_W-1:0] count_i,
    output wdt_ctrl_t        ctrl_o,
    output logic [CNT_W-1:0] load_o,
    output logic             start_o,
    output logic             clear_o,
    output logic [BUS_W-1:0] rdata_o
);

    typedef struct packed {
        wdt_ctrl_t        ctrl;
        logic             locked;
        logic [CNT_W-1:0] load;
    } regs_st_t;

    regs_st_t  st_d, st_q;
    wdt_ctrl_t wr_word;

    assign wr_word = wdt_ctrl_t'(bus_wdata_i & CTRL_WMASK);

    always_comb begin
        st_d    = st_q;
        start_o = 1'b0;
        clear_o = 1'b0;
        if (bus_wr_i) begin
            case (wdt_addr_e'(bus_addr_i))
                A_CTRL: begin
                    if (!st_q.locked) begin
                        st_d.ctrl   = wr_word;
                        st_d.locked = 1'b1;
                        start_o     = wr_word.en;
                    end
                end
                A_LOAD:  st_d.load = bus_wdata_i[CNT_W-1:0];
                A_CLEAR: clear_o   = 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (wdt_addr_e'(bus_addr_i))
            A_CTRL:  rdata_o = BUS_W'(st_q.ctrl);
            A_LOAD:  rdata_o = BUS_W'(st_q.load);
            A_COUNT: rdata_o = BUS_W'(count_i);
            default: rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o = st_q.ctrl;
    assign load_o = st_q.load;

    AST_CTRL_ONCE: assert property (@(posedge clk) disable iff (!rst_n) st_q.locked |=> $stable(st_q.ctrl)) else $error("control changed after lock"); // R3
    AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (bus_addr_i == 2'd2) |-> (rdata_o == '0)) else $error("clear address read nonzero"); // R11

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int MID_LOG = 4,
    parameter int HI_LOG  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       run_i,
    input  logic       restart_i,
    input  logic [1:0] psc_i,
    output logic       step_o
);

    localparam logic [HI_LOG-1:0] LIM_MID = HI_LOG'((1 << MID_LOG) - 1);
    localparam logic [HI_LOG-1:0] LIM_HI  = '1;

    typedef struct packed {
        logic [HI_LOG-1:0] pre;
    } pre_st_t;

    pre_st_t           st_d, st_q;
    logic [HI_LOG-1:0] limit;

    always_comb begin
        case (wdt_psc_e'(psc_i))
            PSC_DIV16:  limit = LIM_MID;
            PSC_DIV256: limit = LIM_HI;
            default:    limit = '0;
        endcase
    end

    always_comb begin
        st_d   = st_q;
        step_o = 1'b0;
        if (restart_i) begin
            st_d.pre = '0;
        end else if (tick_i && run_i) begin
            if (st_q.pre >= limit) begin
                st_d.pre = '0;
                step_o   = 1'b1;
            end else begin
                st_d.pre = st_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_DIV1_EVERY_TICK: assert property (@(posedge clk) disable iff (!rst_n) ((psc_i == 2'd0) && tick_i && run_i && !restart_i) |-> step_o) else $error("divide-by-one missed a tick"); // R2
    AST_FROZEN_PRESCALE: assert property (@(posedge clk) disable iff (!rst_n) (!run_i && !restart_i) |=> $stable(st_q.pre)) else $error("prescaler moved while stopped"); // R10

endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_i,
    input  logic             en_i,
    input  logic             periodic_i,
    input  logic             wd_i,
    input  logic             irq_en_i,
    input  logic [CNT_W-1:0] load_i,
    input  logic             start_i,
    input  logic             clear_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o,
    output logic             rst_req_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
        logic             rst_req;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     clr_evt;
    logic     expire;

    assign clr_evt = clear_i && wd_i && en_i;
    assign expire  = step_i && wd_i && (st_q.cnt <= ONE);

    always_comb begin
        st_d         = st_q;
        st_d.rst_req = 1'b0;
        if (start_i) begin
            st_d.cnt = load_i;
        end else if (clr_evt) begin
            st_d.cnt = load_i;
            st_d.irq = 1'b0;
        end else if (step_i) begin
            if (wd_i) begin
                if (expire) begin
                    st_d.cnt = load_i;
                    if (irq_en_i) begin
                        st_d.irq = 1'b1;
                    end else begin
                        st_d.rst_req = 1'b1;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end else if (up_i) begin
                st_d.cnt = (periodic_i && (st_q.cnt == load_i)) ? '0 : st_q.cnt + ONE;
            end else begin
                st_d.cnt = (periodic_i && (st_q.cnt == '0)) ? load_i : st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o   = st_q.cnt;
    assign irq_o     = st_q.irq;
    assign rst_req_o = st_q.rst_req;

    AST_CLEAR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n) clr_evt |=> (st_q.cnt == $past(load_i))) else $error("clear did not reload"); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(start_i || clr_evt || step_i) |=> $stable(st_q.cnt)) else $error("count moved without cause"); // R6
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (st_q.irq && !clr_evt) |=> st_q.irq) else $error("irq dropped without clear"); // R9
    AST_IRQ_REPLACES_RESET: assert property (@(posedge clk) disable iff (!rst_n) irq_en_i |-> !st_q.rst_req) else $error("reset request while irq selected"); // R9
    AST_WD_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n) (step_i && wd_i && !start_i && !clr_evt && (st_q.cnt > ONE)) |=> (st_q.cnt == $past(st_q.cnt) - ONE)) else $error("watchdog did not count down"); // R7

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PRE_MID_LOG = 4,
    parameter int PRE_HI_LOG  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             pd_i,
    input  logic             bus_wr_i,
    input  logic [1:0]       bus_addr_i,
    input  logic [15:0]      bus_wdata_i,
    output logic [15:0]      bus_rdata_o,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o,
    output logic             rst_req_o
);

    wdt_ctrl_t        ctrl;
    logic [CNT_W-1:0] load;
    logic             start;
    logic             clear;
    logic             step;
    logic             run;

    assign run = ctrl.en && !(ctrl.pd_off && pd_i);

    wdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .count_i     (count_o),
        .ctrl_o      (ctrl),
        .load_o      (load),
        .start_o     (start),
        .clear_o     (clear),
        .rdata_o     (bus_rdata_o)
    );

    wdt_prescaler #(.MID_LOG(PRE_MID_LOG), .HI_LOG(PRE_HI_LOG)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .run_i     (run),
        .restart_i (start),
        .psc_i     (ctrl.psc),
        .step_o    (step)
    );

    wdt_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .up_i       (ctrl.up),
        .en_i       (ctrl.en),
        .periodic_i (ctrl.periodic),
        .wd_i       (ctrl.wd),
        .irq_en_i   (ctrl.irq_en),
        .load_i     (load),
        .start_i    (start),
        .clear_i    (clear),
        .step_i     (step),
        .count_o    (count_o),
        .irq_o      (irq_o),
        .rst_req_o  (rst_req_o)
    );

    AST_PD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) (ctrl.en && ctrl.pd_off && pd_i && !(bus_wr_i && (bus_addr_i == 2'd2))) |=> $stable(count_o)) else $error("count moved during power-down"); // R10
    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!ctrl.en && !start) |=> $stable(count_o)) else $error("count moved while disabled"); // R6

endmodule

// File: tb/wdt_timer_bench.sv
module wdt_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        pd = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic [15:0] count;
    logic        irq;
    logic        rst_req;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    wdt_timer u_wdt_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .pd_i        (pd),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .count_o     (count),
        .irq_o       (irq),
        .rst_req_o   (rst_req)
    );

    // Reference model state
    logic [15:0] m_ctrl, m_load, m_cnt;
    logic [7:0]  m_pre;
    logic        m_lock, m_irq, m_rst;
    string       m_tag;

    function automatic logic [7:0] f_limit(input logic [1:0] psc);
        if (psc == 2'd1) return 8'd15;
        if (psc == 2'd2) return 8'd255;
        return 8'd0;
    endfunction

    function automatic logic [15:0] f_next(input logic [15:0] c, input logic [15:0] cnt, input logic [15:0] ld);
        if (c[8]) return (c[6] && cnt == ld) ? 16'd0 : cnt + 16'd1;
        return (c[6] && cnt == 16'd0) ? ld : cnt - 16'd1;
    endfunction

    function automatic logic [15:0] f_rdata(input logic [1:0] a);
        case (a)
            2'd0:    return m_ctrl;
            2'd1:    return m_load;
            2'd3:    return m_cnt;
            default: return 16'd0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        logic run_v, step_v, start_v;
        if (!rst_n) begin
            m_ctrl <= '0; m_load <= '0; m_cnt <= '0; m_pre <= '0;
            m_lock <= 1'b0; m_irq <= 1'b0; m_rst <= 1'b0; m_tag <= "R1";
        end else begin
            m_rst   <= 1'b0;
            run_v   = m_ctrl[7] && !(m_ctrl[0] && pd);
            start_v = wr && addr == 2'd0 && !m_lock && wdata[7];
            step_v  = 1'b0;
            if (start_v) m_pre <= '0;
            else if (tick && run_v) begin
                if (m_pre >= f_limit(m_ctrl[3:2])) begin m_pre <= '0; step_v = 1'b1; end
                else m_pre <= m_pre + 8'd1;
            end
            m_tag <= !m_ctrl[7] ? "R6" : (m_ctrl[0] && pd) ? "R10" : "R2";
            if (wr && addr == 2'd0 && !m_lock) begin
                m_ctrl <= wdata & 16'h01EF;
                m_lock <= 1'b1;
            end
            if (wr && addr == 2'd1) m_load <= wdata;
            if (start_v) begin
                m_cnt <= m_load; m_tag <= "R6";
            end else if (wr && addr == 2'd2 && m_ctrl[5] && m_ctrl[7]) begin
                m_cnt <= m_load; m_irq <= 1'b0; m_tag <= "R8";
            end else if (step_v) begin
                if (m_ctrl[5]) begin
                    m_tag <= "R7";
                    if (m_cnt <= 16'd1) begin
                        m_cnt <= m_load;
                        if (m_ctrl[1]) m_irq <= 1'b1; else m_rst <= 1'b1;
                    end else m_cnt <= m_cnt - 16'd1;
                end else begin
                    m_tag <= m_ctrl[6] ? "R5" : "R4";
                    m_cnt <= f_next(m_ctrl, m_cnt, m_load);
                end
            end
        end
    end

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        string rtag;
        check(count == m_cnt, m_tag, "count", count, m_cnt);
        check(irq == m_irq, "R9", "irq", {15'd0, irq}, {15'd0, m_irq});
        check(rst_req == m_rst, "R9", "rst_req", {15'd0, rst_req}, {15'd0, m_rst});
        rtag = (addr == 2'd0) ? "R3" : "R11";
        check(rdata == f_rdata(addr), rtag, "rdata", rdata, f_rdata(addr));
    endtask

    // One cycle: check what the last edge produced, then drive the next inputs
    task automatic cycle(input logic w, input logic [1:0] a, input logic [15:0] d, input logic t);
        @(negedge clk);
        #1;
        compare_all();
        wr = w; addr = a; wdata = d; tick = t;
    endtask

    task automatic episode(input logic [15:0] ctrl, input logic [15:0] ld, input int ncyc,
                           input int clr_pm, input int pd_pct);
        @(negedge clk);
        rst_n = 1'b0; wr = 1'b0; tick = 1'b0; pd = 1'b0; addr = 2'd0;
        repeat (2) @(negedge clk);
        #1;
        check(count == 16'd0 && !irq && !rst_req, "R1", "reset outputs", count, 16'd0);
        check(rdata == 16'd0, "R1", "reset control read", rdata, 16'd0);
        rst_n = 1'b1;
        cycle(1'b1, 2'd1, ld, 1'b0);
        cycle(1'b1, 2'd0, ctrl, 1'b0);
        for (int i = 0; i < ncyc; i++) begin
            int r;
            r  = int'($urandom % 1000);
            pd = (int'($urandom % 100) < pd_pct);
            if (r < 4)               cycle(1'b1, 2'd0, 16'($urandom), 1'($urandom));
            else if (r < 10)         cycle(1'b1, 2'd1, 16'($urandom % 24), 1'($urandom));
            else if (r < 10 + clr_pm) cycle(1'b1, 2'd2, 16'($urandom), 1'($urandom));
            else                     cycle(1'b0, 2'($urandom), 16'd0, 1'($urandom));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        episode(16'h0080, 16'd5,    800, 0, 0);   // R4 down free wraps past 0
        episode(16'h0180, 16'hFFF0, 800, 0, 0);   // R4 up free wraps past FFFF
        episode(16'h00C0, 16'd7,    800, 0, 0);   // R5 down periodic
        episode(16'h01C0, 16'd6,    800, 0, 0);   // R5 up periodic
        episode(16'h0084, 16'd3,   1500, 0, 0);   // R2 divide by 16
        episode(16'h0088, 16'd2,   3000, 0, 0);   // R2 divide by 256
        episode(16'h008C, 16'd4,    600, 0, 0);   // R2 reserved code
        episode(16'h00A0, 16'd10,  1000, 0, 0);   // R7 R9 reset request
        episode(16'h00A2, 16'd10,  1000, 15, 0);  // R9 interrupt with clears
        episode(16'h01E2, 16'd8,   1000, 30, 0);  // R7 direction bits ignored
        episode(16'h0081, 16'd9,   1000, 0, 50);  // R10 freeze
        episode(16'h0080, 16'd9,    600, 0, 50);  // R10 pd ignored
        episode(16'h00A1, 16'd6,   1000, 20, 40); // R10 watchdog freeze
        episode(16'h0000, 16'd4,    600, 20, 0);  // R6 disabled hold
        episode(16'h00A0, 16'd0,    400, 0, 0);   // R7 zero load
        episode(16'h0020, 16'd5,    400, 40, 0);  // R8 clear ignored when disabled
        episode(16'hFFFF, 16'd9,   1000, 20, 20); // R11 reserved bits masked
        episode(16'h0180, 16'd3,    400, 60, 0);  // R8 clear ignored outside watchdog
        for (int e = 0; e < 30; e++) begin
            episode(16'($urandom & 32'h1FF) | 16'h0080, 16'($urandom % 32), 1500,
                    int'($urandom % 40), int'($urandom % 40));
        end
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule